// File: doc/BRIEF.md
# Multi-Mode PWM Duty Generator

This block drives six PWM outputs from six 8-bit duty registers. The registers sit on a simple register bus with a clocked write and a combinational read. A two-bit mode input decides how the same register set is read. In byte mode every register sets the duty of its own output. In wide mode, registers are taken in pairs (odd register upper byte, even register lower byte) to form three 16-bit duties. In division mode, the upper nibble of each register sets a coarse duty in sixteenths. The lower nibble adds single extra ticks to some of the sixteen basic pulses of the period, and these extra ticks are spread evenly across it.

All channels share one timebase counter. Its period length follows the active mode. Duty values and the mode are copied into shadow registers only on the first cycle of a period, so a bus write or a mode change never cuts a pulse short in the middle of a period.

Top module: `pwm_multi_gen`

## Requirements
- R1: Six 8-bit duty registers at bus addresses 0 to 5 are written on a rising clock edge while `bus_we` is high, read back combinationally on `bus_rdata`, and reset to 0x00; all outputs are low after reset.
- R2: A write to address 6 or 7 changes no register, and a read of those addresses returns 0x00.
- R3: With mode code 0 (and with the unused code 3), the period is 255 clock cycles and output n is high for exactly m cycles per period, where m is register n, so m = 0 stays low and m = 255 stays high.
- R4: With mode code 1, the value m = {register 2k+1, register 2k} sets a 65535-cycle period in which output 2k is high for exactly m cycles.
- R5: With mode code 1, outputs 1, 3 and 5 are held low.
- R6: A register write or a mode change reaches the outputs only from the first cycle of the next period; until then the outputs keep the pattern of the current period.
- R7: With mode code 2, the period is 256 cycles made of 16 basic pulses of 16 cycles, and output n is high for 16·U + L cycles per period, where U is bits 7:4 and L is bits 3:0 of register n.
- R8: With mode code 2, basic pulse k (k = 0 to 15, cycles 16k to 16k+15 of the period) is high for its first U cycles plus one more cycle when the bit-reversed 4-bit value of k is below L; so L = 1 marks only cycle 0 and L = 2 with U = 0 gives single high cycles exactly 128 cycles apart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr` |
| mode_sel | input | 2 | 0 byte, 1 wide, 2 division, 3 same as 0 |
| pwm_out | output | 6 | PWM outputs, bit n belongs to register n |

## Verification
Properties run on every cycle and cover the counter stepping and restarting at the period boundary, shadow copies and the active mode staying frozen between boundaries, ignored out-of-range writes, quiet odd outputs in wide mode, and the fixed end values of byte and division duties. Whether a period holds exactly the high-cycle count the formulas give, and whether division-mode extra ticks fall at the expected positions, needs whole periods of observation. The bench scenarios supply that by counting high cycles over full period windows in all three modes with end values and mixed values, and by locking onto a one-cycle marker channel to check pulse positions and when a write takes effect.

// File: rtl/pwm_pkg.sv
package pwm_pkg;
  typedef enum logic [1:0] {
    MODE_BYTE = 2'd0,
    MODE_WIDE = 2'd1,
    MODE_DIV  = 2'd2,
    MODE_RSVD = 2'd3
  } pwm_mode_t;
endpackage

// File: rtl/pwm_timebase.sv
module pwm_timebase
  import pwm_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  pwm_mode_t       mode,
  output logic [2*DW-1:0] cnt,
  output logic            wrap
);
  localparam int CW = 2 * DW;
  localparam logic [CW-1:0] LAST_BYTE = CW'((1 << DW) - 2);
  localparam logic [CW-1:0] LAST_WIDE = CW'((1 << CW) - 2);
  localparam logic [CW-1:0] LAST_DIV  = CW'((1 << DW) - 1);

  logic [CW-1:0] cnt_q, cnt_d, last;
  logic          cnt_en;

  always_comb begin
    unique case (mode)
      MODE_WIDE: last = LAST_WIDE;
      MODE_DIV:  last = LAST_DIV;
      default:   last = LAST_BYTE;
    endcase
    cnt_en = 1'b1;
    wrap   = (cnt_q == last);
    cnt_d  = wrap ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign cnt = cnt_q;

  // R6: a new period always starts from zero
  p_restart_r6: assert property (@(posedge clk) disable iff (!rst_n)
    wrap |=> (cnt_q == '0));
  // R3: inside a period the count advances by one per cycle
  p_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !wrap |=> (cnt_q == $past(cnt_q) + 1'b1));
endmodule

// File: rtl/pwm_duty_regs.sv
module pwm_duty_regs
  import pwm_pkg::*;
#(
  parameter int NCH = 6,
  parameter int DW  = 8,
  parameter int AW  = 3
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     we,
  input  logic [AW-1:0]            addr,
  input  logic [DW-1:0]            wdata,
  output logic [DW-1:0]            rdata,
  input  logic                     wrap,
  input  pwm_mode_t                mode_in,
  output logic [NCH-1:0][DW-1:0]   act_duty,
  output pwm_mode_t                act_mode
);
  logic [NCH-1:0][DW-1:0] reg_q, reg_d, act_q, act_d;
  pwm_mode_t              mode_q, mode_d;
  logic                   hit;

  always_comb begin
    reg_d = reg_q;
    hit   = 1'b0;
    rdata = '0;
    for (int i = 0; i < NCH; i++) begin
      if (addr == AW'(i)) begin
        hit   = 1'b1;
        rdata = reg_q[i];
        if (we) reg_d[i] = wdata;
      end
    end
    act_d  = act_q;
    mode_d = mode_q;
    if (wrap) begin
      act_d  = reg_q;
      mode_d = mode_in;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      reg_q  <= '0;
      act_q  <= '0;
      mode_q <= MODE_BYTE;
    end else begin
      reg_q  <= reg_d;
      act_q  <= act_d;
      mode_q <= mode_d;
    end
  end

  assign act_duty = act_q;
  assign act_mode = mode_q;

  // R2: stray addresses leave the register set alone
  p_stray_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (we && !hit) |=> (reg_q == $past(reg_q)));
  // R6: shadow duty and mode frozen between period boundaries
  p_shadow_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !wrap |=> (act_q == $past(act_q)) && (mode_q == $past(mode_q)));
  // R6: boundary copies the bus-visible values
  p_shadow_load_r6: assert property (@(posedge clk) disable iff (!rst_n)
    wrap |=> (act_q == $past(reg_q)));
endmodule

// File: rtl/pwm_pair_cmp.sv
module pwm_pair_cmp
  import pwm_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  pwm_mode_t       mode,
  input  logic [2*DW-1:0] cnt,
  input  logic [DW-1:0]   lo,
  input  logic [DW-1:0]   hi,
  output logic            out_lo,
  output logic            out_hi
);
  localparam int H = DW / 2;

  logic [1:0][DW-1:0] lane;
  logic [H-1:0]       idx, tick, rev;
  logic [1:0]         extra, div_hi;

  always_comb begin
    lane = {hi, lo};
    idx  = cnt[DW-1:H];
    tick = cnt[H-1:0];
    for (int b = 0; b < H; b++) rev[b] = idx[H-1-b];
    for (int l = 0; l < 2; l++) begin
      extra[l]  = (lane[l][H-1:0] > rev);
      div_hi[l] = ({1'b0, tick} < ({1'b0, lane[l][DW-1:H]} + {{H{1'b0}}, extra[l]}));
    end
    unique case (mode)
      MODE_WIDE: begin
        out_lo = (cnt < {hi, lo});
        out_hi = 1'b0;
      end
      MODE_DIV: begin
        out_lo = div_hi[0];
        out_hi = div_hi[1];
      end
      default: begin
        out_lo = (cnt < {{DW{1'b0}}, lo});
        out_hi = (cnt < {{DW{1'b0}}, hi});
      end
    endcase
  end

  // R5: upper channel of a cascaded pair stays quiet
  p_odd_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_WIDE) |-> !out_hi);
  // R3: full-scale byte duty never drops
  p_byte_full_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ((mode == MODE_BYTE) && (lo == '1)) |-> out_lo);
  // R7: zero division setting never rises
  p_div_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ((mode == MODE_DIV) && (lo == '0)) |-> !out_lo);
endmodule

// File: rtl/pwm_multi_gen.sv
module pwm_multi_gen
  import pwm_pkg::*;
#(
  parameter int NCH = 6,
  parameter int DW  = 8,
  parameter int AW  = 3
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           bus_we,
  input  logic [AW-1:0]  bus_addr,
  input  logic [DW-1:0]  bus_wdata,
  output logic [DW-1:0]  bus_rdata,
  input  logic [1:0]     mode_sel,
  output logic [NCH-1:0] pwm_out
);
  localparam int NPAIR = NCH / 2;

  logic                   rst_meta, rst_sync;
  logic [2*DW-1:0]        cnt;
  logic                   wrap;
  logic [NCH-1:0][DW-1:0] act_duty;
  pwm_mode_t              act_mode;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_sync <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_sync <= rst_meta;
    end
  end

  pwm_timebase #(.DW(DW)) u_tb (
    .clk  (clk),
    .rst_n(rst_sync),
    .mode (act_mode),
    .cnt  (cnt),
    .wrap (wrap)
  );

  pwm_duty_regs #(.NCH(NCH), .DW(DW), .AW(AW)) u_regs (
    .clk     (clk),
    .rst_n   (rst_sync),
    .we      (bus_we),
    .addr    (bus_addr),
    .wdata   (bus_wdata),
    .rdata   (bus_rdata),
    .wrap    (wrap),
    .mode_in (pwm_mode_t'(mode_sel)),
    .act_duty(act_duty),
    .act_mode(act_mode)
  );

  for (genvar p = 0; p < NPAIR; p++) begin : g_pair
    pwm_pair_cmp #(.DW(DW)) u_cmp (
      .clk   (clk),
      .rst_n (rst_sync),
      .mode  (act_mode),
      .cnt   (cnt),
      .lo    (act_duty[2*p]),
      .hi    (act_duty[2*p+1]),
      .out_lo(pwm_out[2*p]),
      .out_hi(pwm_out[2*p+1])
    );
  end

  // R1: outputs quiet in the first cycle after reset release
  p_reset_quiet_r1: assert property (@(posedge clk) disable iff (!rst_sync)
    $rose(rst_sync) |-> (pwm_out == '0));
endmodule

// File: tb/tb_pwm_multi_gen.sv
module tb_pwm_multi_gen;
  localparam int NCH = 6;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       bus_we;
  logic [2:0] bus_addr;
  logic [7:0] bus_wdata;
  logic [7:0] bus_rdata;
  logic [1:0] mode_sel;
  logic [5:0] pwm_out;

  always #2.5 clk = ~clk;

  pwm_multi_gen dut (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .mode_sel(mode_sel),
    .pwm_out(pwm_out)
  );

  typedef struct {
    string tag;
    int    ch;
    int    exp;
  } sb_item_t;

  sb_item_t sb[$];
  int  total = 0;
  int  bad   = 0;
  int  win_len;
  bit  finished = 0;
  event ev_go, ev_done;

  task automatic check(string tag, int got, int exp, string what);
    total++;
    if (got != exp) begin
      bad++;
      $display("FAIL %s %s: got %0d expected %0d", tag, what, got, exp);
    end
  endtask

  task automatic wr(input int a, input int d);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = 3'(a); bus_wdata = 8'(d);
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd_chk(string tag, input int a, input int exp);
    @(negedge clk);
    bus_addr = 3'(a);
    #1;
    check(tag, int'(bus_rdata), exp, $sformatf("read addr %0d", a));
  endtask

  task automatic push(string tag, input int ch, input int exp);
    sb_item_t it;
    it.tag = tag; it.ch = ch; it.exp = exp;
    sb.push_back(it);
  endtask

  task automatic run_window(input int len);
    win_len = len;
    -> ev_go;
    @(ev_done);
  endtask

  // monitor: counts high cycles over a window and retires queued items
  initial begin
    int hi_cnt[NCH];
    forever begin
      @(ev_go);
      for (int c = 0; c < NCH; c++) hi_cnt[c] = 0;
      for (int k = 0; k < win_len; k++) begin
        @(negedge clk);
        for (int c = 0; c < NCH; c++) if (pwm_out[c]) hi_cnt[c]++;
      end
      while (sb.size() > 0) begin
        sb_item_t it;
        it = sb.pop_front();
        check(it.tag, hi_cnt[it.ch], it.exp, $sformatf("high count ch%0d", it.ch));
      end
      -> ev_done;
    end
  end

  task automatic settle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_marker(input int ch);
    for (int k = 0; k < 700; k++) begin
      @(negedge clk);
      if (pwm_out[ch]) return;
    end
  endtask

  initial begin
    int vals[NCH];
    int errs;
    rst_n = 1'b0; bus_we = 1'b0; bus_addr = '0; bus_wdata = '0; mode_sel = 2'd0;
    settle(5);
    rst_n = 1'b1;
    settle(5);

    // R1 reset state
    check("R1", int'(pwm_out), 0, "outputs after reset");
    for (int a = 0; a < NCH; a++) rd_chk("R1", a, 0);

    // R2 stray addresses
    wr(6, 8'hAA);
    wr(7, 8'h55);
    rd_chk("R2", 6, 0);
    rd_chk("R2", 7, 0);
    for (int a = 0; a < NCH; a++) rd_chk("R2", a, 0);

    // R3 byte mode with end values
    vals = '{0, 255, 1, 128, 77, 200};
    for (int c = 0; c < NCH; c++) wr(c, vals[c]);
    for (int c = 0; c < NCH; c++) rd_chk("R1", c, vals[c]);
    settle(600);
    for (int c = 0; c < NCH; c++) push("R3", c, vals[c]);
    run_window(255);

    // R3 unused code 3 acts as byte mode, random values
    mode_sel = 2'd3;
    for (int c = 0; c < NCH; c++) begin
      vals[c] = int'($urandom_range(0, 255));
      wr(c, vals[c]);
    end
    settle(600);
    for (int c = 0; c < NCH; c++) push("R3", c, vals[c]);
    run_window(255);

    // R6 mid-period write held back until the next period
    mode_sel = 2'd0;
    wr(0, 0);
    wr(1, 1);
    settle(600);
    wait_marker(1);
    settle(10);
    wr(0, 200);
    errs = 0;
    for (int k = 0; k < 300; k++) begin
      @(negedge clk);
      if (pwm_out[1]) break;
      if (pwm_out[0]) errs++;
    end
    check("R6", errs, 0, "early high cycles on ch0 before boundary");
    check("R6", int'(pwm_out[0]), 1, "ch0 at first cycle of next period");
    push("R6", 0, 200);
    run_window(255);

    // R7 division mode counts
    vals = '{8'h00, 8'hFF, 8'h35, 8'h01, 8'h02, 8'h8A};
    for (int c = 0; c < NCH; c++) wr(c, vals[c]);
    mode_sel = 2'd2;
    settle(600);
    for (int c = 0; c < NCH; c++) push("R7", c, 16 * (vals[c] >> 4) + (vals[c] & 15));
    run_window(256);

    // R8 extra-tick placement: ch3 (0x01) marks cycle 0, ch4 (0x02) hits 0 and 128
    wait_marker(3);
    errs = 0;
    for (int k = 0; k < 256; k++) begin
      if (k != 0) @(negedge clk);
      if (int'(pwm_out[4]) != int'(k == 0 || k == 128)) errs++;
    end
    check("R8", errs, 0, "ch4 pulse positions mismatches");

    // R7 random division values
    for (int c = 0; c < NCH; c++) begin
      vals[c] = int'($urandom_range(0, 255));
      wr(c, vals[c]);
    end
    settle(600);
    for (int c = 0; c < NCH; c++) push("R7", c, 16 * (vals[c] >> 4) + (vals[c] & 15));
    run_window(256);

    // R4/R5 wide mode: pairs 0x0000, 0xFFFF, 0x1234
    vals = '{8'h00, 8'h00, 8'hFF, 8'hFF, 8'h34, 8'h12};
    for (int c = 0; c < NCH; c++) wr(c, vals[c]);
    mode_sel = 2'd1;
    settle(300);
    push("R4", 0, 0);
    push("R4", 2, 65535);
    push("R4", 4, 16'h1234);
    push("R5", 1, 0);
    push("R5", 3, 0);
    push("R5", 5, 0);
    run_window(65535);

    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (195000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      total++;
      bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule